// File: doc/BRIEF.md
# Phase Sequencer with Shift-Register Timing

This block is the control unit of a small pseudorandom bit generator. After reset it steps through three phases: a loading phase in which the datapath shifts in key and seed material, a mixing phase in which the datapath runs its feedback without producing output, and an output phase that lasts until the next reset. It drives one flag per phase and one clock enable for the datapath's word-wide register. It also gives two single-cycle strobes that tell the datapath when to begin taking its second serial lane and its five-bit word lane during loading.

Phase lengths are timed with a six-bit maximal-length shift register whose feedback follows x^6 + x + 1. The register is loaded with all ones on entry to each phase. A phase ends when the register matches a terminal state, and those terminal states are computed at elaboration from the phase lengths. In the output phase a small modulo-5 counter raises the enable on one cycle in every five.

Top module: `lfsr_phase_sequencer`

Cycle k counts the clock edges taken with reset released. Cycle 0 is the cycle in which reset has just been released.

## Requirements
- R1: Exactly one of `load_o`, `init_o`, `run_o` is high in every cycle. Read as the vector {load, init, run}, the phases are 100 (loading), 010 (mixing) and 001 (output).
- R2: While `rst_n` is low at a clock edge, the next cycle is in the loading phase with the enable high and both strobes low.
- R3: Loading lasts 18 cycles, covering cycles 0 to 17.
- R4: Mixing lasts 36 cycles, covering cycles 18 to 53. Output begins at cycle 54 and never ends without a reset.
- R5: `en_o` is high in every loading cycle.
- R6: `en_o` is low in the first mixing cycle (cycle 18) and high in the other 35 mixing cycles.
- R7: In the output phase `en_o` follows 0,0,0,0,1 repeated, counted from the first output cycle, so it is high at cycles 58, 63, 68 and so on.
- R8: `lane2_stb_o` is high only at cycle 1 and `word_stb_o` only at cycle 12. Neither is high outside loading.
- R9: A reset taken during the output phase restarts the whole sequence from loading cycle 0, with the same timing as after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_o | output | 1 | Loading phase flag |
| init_o | output | 1 | Mixing phase flag |
| run_o | output | 1 | Output phase flag |
| en_o | output | 1 | Clock enable for the datapath word register |
| lane2_stb_o | output | 1 | One-cycle pulse: begin taking the second serial lane |
| word_stb_o | output | 1 | One-cycle pulse: begin taking the five-bit word lane |

## Verification
The checker tests on every cycle the one-hot phase flags, the length of each phase as measured by its own age counter, the enable level in each phase, the five-cycle spacing of output-phase enables, and the strobe positions. These checks do not depend on absolute cycle numbers. The bench compares every output against a model indexed by absolute cycle number over the whole sequence and well into the output phase. It also applies a reset in the middle of the output phase. Only the bench shows that a restart repeats the exact timing and that the computed terminal states land on the cycles called for.

// File: rtl/seq_pkg.sv
// Package: shared phase encoding for the sequencer.
// Assumes: one-hot vector ordered {loading, mixing, output}.
package seq_pkg;
    typedef enum logic [2:0] {
        PH_LOAD = 3'b100,
        PH_INIT = 3'b010,
        PH_RUN  = 3'b001
    } phase_e;
endpackage

// File: rtl/seq_lfsr.sv
// Module: seq_lfsr
// Fibonacci shift-register counter. It loads SEED on reset or restart and
// otherwise advances when adv is high.
// Assumes: FB_MASK selects the taps whose XOR becomes the new low bit.
module seq_lfsr #(
    parameter int unsigned W       = 6,
    parameter logic [W-1:0] FB_MASK = 6'b110000,
    parameter logic [W-1:0] SEED    = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         adv,
    output logic [W-1:0] q
);
    logic fb;

    // Feedback bit: parity of the tapped stages.
    always_comb fb = ^(q & FB_MASK);

    // State update: seed, shift, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) q <= SEED;
        else if (adv)          q <= {q[W-2:0], fb};
    end
endmodule

// File: rtl/seq_phase_fsm.sv
// Module: seq_phase_fsm
// Holds the one-hot phase. It moves loading -> mixing -> output when the
// counter matches the terminal state of the current phase, and requests a
// counter reseed on each move.
// Assumes: the counter is seeded on entry to each phase.
module seq_phase_fsm
    import seq_pkg::*;
#(
    parameter int unsigned  W         = 6,
    parameter logic [W-1:0] LOAD_TERM = '0,
    parameter logic [W-1:0] INIT_TERM = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    output phase_e       phase,
    output logic         restart
);
    phase_e phase_nx;

    // Next-phase decode from the terminal match.
    always_comb begin
        phase_nx = phase;
        restart  = 1'b0;
        unique case (phase)
            PH_LOAD: if (cnt == LOAD_TERM) begin phase_nx = PH_INIT; restart = 1'b1; end
            PH_INIT: if (cnt == INIT_TERM) begin phase_nx = PH_RUN;  restart = 1'b1; end
            default: phase_nx = PH_RUN;
        endcase
    end

    // Phase register; reset forces loading.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_LOAD;
        else        phase <= phase_nx;
    end
endmodule

// File: rtl/seq_enable_gen.sv
// Module: seq_enable_gen
// Builds the word-register enable and the two lane-start strobes from the
// phase and the counter state.
// Assumes: the counter holds SEED in the first cycle of each phase.
module seq_enable_gen
    import seq_pkg::*;
#(
    parameter int unsigned  W          = 6,
    parameter logic [W-1:0] SEED       = '1,
    parameter logic [W-1:0] LANE2_TERM = '0,
    parameter logic [W-1:0] WORD_TERM  = '0,
    parameter int unsigned  RUN_PERIOD = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  phase_e       phase,
    input  logic [W-1:0] cnt,
    output logic         en,
    output logic         lane2_stb,
    output logic         word_stb
);
    localparam int unsigned RW = (RUN_PERIOD > 1) ? $clog2(RUN_PERIOD) : 1;
    localparam logic [RW-1:0] RLAST = RW'(RUN_PERIOD - 1);

    logic [RW-1:0] rcnt;

    // Modulo counter for the output phase; held at zero until output begins.
    always_ff @(posedge clk) begin
        if (!rst_n || phase != PH_RUN) rcnt <= '0;
        else if (rcnt == RLAST)        rcnt <= '0;
        else                           rcnt <= rcnt + 1'b1;
    end

    // Enable pattern selected by phase.
    always_comb begin
        unique case (phase)
            PH_LOAD: en = 1'b1;
            PH_INIT: en = (cnt != SEED);
            default: en = (rcnt == RLAST);
        endcase
    end

    // Lane-start strobes: single counter states inside loading.
    always_comb begin
        lane2_stb = (phase == PH_LOAD) && (cnt == LANE2_TERM);
        word_stb  = (phase == PH_LOAD) && (cnt == WORD_TERM);
    end
endmodule

// File: rtl/lfsr_phase_sequencer.sv
// Module: lfsr_phase_sequencer (top)
// Three-phase sequencer timed by a shift-register counter. Terminal states
// are computed at elaboration from the phase lengths.
// Assumes: every length and strobe position is below 2**CNT_W - 1, and the
// strobe positions lie inside loading.
module lfsr_phase_sequencer
    import seq_pkg::*;
#(
    parameter int unsigned         LOAD_LEN   = 18,
    parameter int unsigned         INIT_LEN   = 36,
    parameter int unsigned         LANE2_AT   = 1,
    parameter int unsigned         WORD_AT    = 12,
    parameter int unsigned         RUN_PERIOD = 5,
    parameter int unsigned         CNT_W      = 6,
    parameter logic [CNT_W-1:0]    FB_MASK    = 6'b110000
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_o,
    output logic init_o,
    output logic run_o,
    output logic en_o,
    output logic lane2_stb_o,
    output logic word_stb_o
);
    localparam logic [CNT_W-1:0] SEED = '1;

    // Counter state reached from SEED after n steps.
    function automatic logic [CNT_W-1:0] state_after(int unsigned n);
        logic [CNT_W-1:0] s;
        s = SEED;
        for (int unsigned i = 0; i < n; i++) s = {s[CNT_W-2:0], ^(s & FB_MASK)};
        return s;
    endfunction

    localparam logic [CNT_W-1:0] LOAD_TERM  = state_after(LOAD_LEN - 1);
    localparam logic [CNT_W-1:0] INIT_TERM  = state_after(INIT_LEN - 1);
    localparam logic [CNT_W-1:0] LANE2_TERM = state_after(LANE2_AT);
    localparam logic [CNT_W-1:0] WORD_TERM  = state_after(WORD_AT);

    phase_e           phase;
    logic             restart;
    logic [CNT_W-1:0] cnt;

    seq_lfsr #(.W(CNT_W), .FB_MASK(FB_MASK), .SEED(SEED)) lfsr_i (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .adv(phase != PH_RUN), .q(cnt)
    );

    seq_phase_fsm #(.W(CNT_W), .LOAD_TERM(LOAD_TERM), .INIT_TERM(INIT_TERM)) fsm_i (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .phase(phase), .restart(restart)
    );

    seq_enable_gen #(
        .W(CNT_W), .SEED(SEED), .LANE2_TERM(LANE2_TERM),
        .WORD_TERM(WORD_TERM), .RUN_PERIOD(RUN_PERIOD)
    ) engen_i (
        .clk(clk), .rst_n(rst_n), .phase(phase), .cnt(cnt),
        .en(en_o), .lane2_stb(lane2_stb_o), .word_stb(word_stb_o)
    );

    // Split the one-hot phase onto its flag ports.
    always_comb {load_o, init_o, run_o} = phase;
endmodule

// File: rtl/seq_phase_chk.sv
// Module: seq_phase_chk
// Checker bound to the top. It keeps its own phase-age and enable-gap
// counters and checks the phase order, the phase lengths, the enable
// pattern and the strobe placement.
module seq_phase_chk #(
    parameter int unsigned LOAD_LEN   = 18,
    parameter int unsigned INIT_LEN   = 36,
    parameter int unsigned LANE2_AT   = 1,
    parameter int unsigned WORD_AT    = 12,
    parameter int unsigned RUN_PERIOD = 5
) (
    input logic clk,
    input logic rst_n,
    input logic load_o,
    input logic init_o,
    input logic run_o,
    input logic en_o,
    input logic lane2_stb_o,
    input logic word_stb_o
);
    int unsigned age;
    int unsigned gap;
    logic        p_load, p_init, p_run;

    // Age within the current phase, measured from the flags alone.
    always_ff @(posedge clk) begin
        p_load <= load_o; p_init <= init_o; p_run <= run_o;
        if (!rst_n) age <= 0;
        else if ({load_o, init_o, run_o} != {p_load, p_init, p_run} && age != 0) age <= 1;
        else if (age < 1000) age <= age + 1;
    end

    // Cycles since the last output-phase enable or since output began.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_o || en_o) gap <= 0;
        else                          gap <= gap + 1;
    end

    // The flag vector changes exactly when a new phase starts.
    logic         ph_chg;
    int unsigned  ph_age;
    always_comb begin
        ph_chg = ({load_o, init_o, run_o} != {p_load, p_init, p_run});
        ph_age = ph_chg ? 0 : age;
    end

    assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({load_o, init_o, run_o}) == 1);
    assert_reset_load_R2: assert property (@(posedge clk)
        !rst_n |=> (load_o && !init_o && !run_o && en_o && !lane2_stb_o && !word_stb_o));
    assert_load_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> ph_age < LOAD_LEN);
    assert_load_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_o) |-> $past(load_o) && $past(ph_age) == LOAD_LEN - 1);
    assert_init_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |-> ph_age < INIT_LEN);
    assert_init_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> $past(init_o) && $past(ph_age) == INIT_LEN - 1);
    assert_run_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |=> run_o);
    assert_load_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> en_o);
    assert_init_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |-> (en_o == (ph_age != 0)));
    assert_run_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> (en_o == (gap == RUN_PERIOD - 1)));
    assert_strobe_lane2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lane2_stb_o == (load_o && ph_age == LANE2_AT));
    assert_strobe_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb_o == (load_o && ph_age == WORD_AT));
endmodule

bind lfsr_phase_sequencer seq_phase_chk #(
    .LOAD_LEN(LOAD_LEN), .INIT_LEN(INIT_LEN), .LANE2_AT(LANE2_AT),
    .WORD_AT(WORD_AT), .RUN_PERIOD(RUN_PERIOD)
) chk_i (
    .clk(clk), .rst_n(rst_n), .load_o(load_o), .init_o(init_o), .run_o(run_o),
    .en_o(en_o), .lane2_stb_o(lane2_stb_o), .word_stb_o(word_stb_o)
);

// File: tb/lfsr_phase_sequencer_tb_top.sv
// Directed bench: one task for each scenario, each comparing outputs to a
// cycle-indexed model built from the requirements.
module lfsr_phase_sequencer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_o, init_o, run_o, en_o, lane2_stb_o, word_stb_o;
    int   n_chk = 0;
    int   n_err = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    lfsr_phase_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .load_o(load_o), .init_o(init_o), .run_o(run_o),
        .en_o(en_o), .lane2_stb_o(lane2_stb_o), .word_stb_o(word_stb_o)
    );

    task automatic check(input string req, input int k, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s cycle %0d: {load,init,run,en,lane2,word} actual=%b expected=%b", req, k, act, exp);
        end
    endtask

    // Expected outputs at cycle k after reset release.
    function automatic logic [5:0] model(int k);
        logic l, i, r, e;
        l = (k < 18);
        i = (k >= 18) && (k < 54);
        r = (k >= 54);
        if (l)      e = 1'b1;
        else if (i) e = (k != 18);
        else        e = ((k - 54) % 5 == 4);
        return {l, i, r, e, (k == 1), (k == 12)};
    endfunction

    function automatic string req_of(int k);
        if (k == 1 || k == 12) return "R8";
        if (k < 18)  return (k == 17) ? "R3" : "R5";
        if (k == 18) return "R6";
        if (k < 54)  return (k == 53) ? "R4" : "R6";
        return (k == 54) ? "R4" : "R7";
    endfunction

    // Hold reset for a few edges, then release at a falling edge.
    task automatic apply_reset(input string req);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req, -1, {load_o, init_o, run_o, en_o, lane2_stb_o, word_stb_o}, 6'b100100);
        rst_n = 1'b1;
    endtask

    // Walk ncyc cycles after release and compare every output each cycle.
    task automatic walk(input int ncyc, input string tag);
        logic [5:0] v;
        for (int k = 0; k < ncyc; k++) begin
            if (k > 0) begin @(posedge clk); @(negedge clk); end
            v = {load_o, init_o, run_o, en_o, lane2_stb_o, word_stb_o};
            check({tag, req_of(k)}, k, v, model(k));
            if ($countones(v[5:3]) != 1) check("R1", k, v, model(k));
        end
    endtask

    task automatic t_reset_state;  apply_reset("R2");                 endtask
    task automatic t_full_sequence; walk(130, "");                    endtask
    task automatic t_restart;
        apply_reset("R9 R2");
        walk(80, "R9/");
    endtask

    initial begin
        t_reset_state();
        t_full_sequence();
        t_restart();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin repeat (20000) @(posedge clk); end
        join_any
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule